// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block decides, for each of the two ALU operands of the execute stage in a five-stage in-order pipeline, where the operand value comes from. It compares the two source register numbers carried into execute against the destination register numbers of the two older instructions still in flight: the one just past execute and the one about to write back. When a match shows that a newer value is still on its way to the register file, the block steers that value to the ALU in place of the stale register-file read.

Each operand has a 2-bit select code and a 3:1 operand multiplexer. The instruction closer to execute always wins over the older one. Register zero is hard-wired and never forwards. The block is purely combinational and settles within the execute cycle. The register file, stall generation and decode-stage branch comparison sit outside it.

Top module: `fwd_unit`

## Requirements
- R1: When the write enable of the stage just past execute is 1, its destination is nonzero and equals an operand's source number, that operand's select is 2'b10 and the operand carries that stage's result.
- R2: When only the write-back stage qualifies (write enable 1, nonzero destination equal to the source), the operand's select is 2'b01 and the operand carries the write-back result.
- R3: When both stages qualify for the same operand, the stage just past execute wins: select 2'b10 and its result, as in three back-to-back adds that each read and write one register.
- R4: A destination number of 0 never forwards, whatever the write enable, and the operand reads the register file.
- R5: A stage whose write enable is 0 never forwards, even when its destination matches; the other stage may still forward.
- R6: With no qualifying match, including while reset is held with all inputs zero, the select is 2'b00 and the operand equals the register-file read for that operand.
- R7: Operand A (source A number) and operand B (source B number) are decided independently; both may forward from the same stage, or from different stages, in the same cycle.
- R8: The select code 2'b11 is never produced on either operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a_idx | input | REG_W (5) | Source register number for operand A in execute |
| src_b_idx | input | REG_W (5) | Source register number for operand B in execute |
| exm_dst | input | REG_W (5) | Destination number of the instruction just past execute |
| exm_wen | input | 1 | Register write enable of the instruction just past execute |
| exm_res | input | DATA_W (32) | Result of the instruction just past execute |
| mwb_dst | input | REG_W (5) | Destination number of the instruction in write-back |
| mwb_wen | input | 1 | Register write enable of the instruction in write-back |
| mwb_res | input | DATA_W (32) | Value being written back |
| rf_a_data | input | DATA_W (32) | Register-file read for operand A |
| rf_b_data | input | DATA_W (32) | Register-file read for operand B |
| sel_a | output | 2 | Forward select for operand A |
| sel_b | output | 2 | Forward select for operand B |
| op_a | output | DATA_W (32) | Operand A to the ALU |
| op_b | output | DATA_W (32) | Operand B to the ALU |

## Verification
The hardest case is the one where both older stages name the same nonzero register as an operand source with both write enables set, while the register-file value differs from both results; only then does a wrong priority show at the ports. The stimulus builds it from the three-dependent-add pattern, stepping the pipeline fields cycle by cycle. Table vectors mix it with the disabled-write and register-zero cases, and a pseudo-random sweep over only four register numbers makes such collisions frequent on both operands at once.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

   typedef enum logic [1:0] {
      FWD_RF    = 2'b00,
      FWD_LATE  = 2'b01,
      FWD_EARLY = 2'b10,
      FWD_RSVD  = 2'b11
   } fwd_sel_e;

   localparam int NUM_OPS = 2;

endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
   parameter int REG_W = 5
) (
   input  logic [REG_W-1:0] src_idx,
   input  logic [REG_W-1:0] dst_idx,
   input  logic             dst_wen,
   output logic             hit
);
   logic dst_live;
   assign dst_live = dst_wen && (dst_idx != '0);
   assign hit      = dst_live && (dst_idx == src_idx);
endmodule

// File: rtl/fwd_select.sv
module fwd_select
   import fwd_pkg::*;
(
   input  logic     hit_early,
   input  logic     hit_late,
   output fwd_sel_e sel
);
   always_comb begin
      if (hit_early)     sel = FWD_EARLY;
      else if (hit_late) sel = FWD_LATE;
      else               sel = FWD_RF;
   end
endmodule

// File: rtl/fwd_opmux.sv
module fwd_opmux #(
   parameter int DATA_W    = 32,
   parameter int MUX_STYLE = 0
) (
   input  logic [1:0]        sel,
   input  logic [DATA_W-1:0] rf_val,
   input  logic [DATA_W-1:0] early_val,
   input  logic [DATA_W-1:0] late_val,
   output logic [DATA_W-1:0] op_val
);
   generate
      if (MUX_STYLE == 0) begin : g_case
         always_comb begin
            case (sel)
               2'b10:   op_val = early_val;
               2'b01:   op_val = late_val;
               default: op_val = rf_val;
            endcase
         end
      end else begin : g_andor
         logic pick_e, pick_l, pick_r;
         assign pick_e = sel[1] & ~sel[0];
         assign pick_l = sel[0] & ~sel[1];
         assign pick_r = ~(pick_e | pick_l);
         assign op_val = ({DATA_W{pick_e}} & early_val)
                       | ({DATA_W{pick_l}} & late_val)
                       | ({DATA_W{pick_r}} & rf_val);
      end
   endgenerate
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
   import fwd_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int REG_CNT   = 32,
   parameter int MUX_STYLE = 0,
   localparam int REG_W    = $clog2(REG_CNT)
) (
   input  logic [REG_W-1:0]  src_a_idx,
   input  logic [REG_W-1:0]  src_b_idx,
   input  logic [REG_W-1:0]  exm_dst,
   input  logic              exm_wen,
   input  logic [DATA_W-1:0] exm_res,
   input  logic [REG_W-1:0]  mwb_dst,
   input  logic              mwb_wen,
   input  logic [DATA_W-1:0] mwb_res,
   input  logic [DATA_W-1:0] rf_a_data,
   input  logic [DATA_W-1:0] rf_b_data,
   output logic [1:0]        sel_a,
   output logic [1:0]        sel_b,
   output logic [DATA_W-1:0] op_a,
   output logic [DATA_W-1:0] op_b
);
   generate
      if (REG_CNT < 2 || (REG_CNT & (REG_CNT - 1)) != 0) begin : g_bad_regs
         $error("fwd_unit: REG_CNT must be a power of two of at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("fwd_unit: DATA_W must be positive");
      end
      if (MUX_STYLE < 0 || MUX_STYLE > 1) begin : g_bad_style
         $error("fwd_unit: MUX_STYLE must be 0 or 1");
      end
   endgenerate

   logic [REG_W-1:0]  src_v [NUM_OPS];
   logic [DATA_W-1:0] rf_v  [NUM_OPS];
   logic [1:0]        sel_v [NUM_OPS];
   logic [DATA_W-1:0] op_v  [NUM_OPS];

   assign src_v[0] = src_a_idx;
   assign src_v[1] = src_b_idx;
   assign rf_v[0]  = rf_a_data;
   assign rf_v[1]  = rf_b_data;

   generate
      for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
         logic     hit_e, hit_l;
         fwd_sel_e sel_e;

         fwd_match #(.REG_W(REG_W)) u_match_early (
            .src_idx (src_v[g]),
            .dst_idx (exm_dst),
            .dst_wen (exm_wen),
            .hit     (hit_e)
         );

         fwd_match #(.REG_W(REG_W)) u_match_late (
            .src_idx (src_v[g]),
            .dst_idx (mwb_dst),
            .dst_wen (mwb_wen),
            .hit     (hit_l)
         );

         fwd_select u_select (
            .hit_early (hit_e),
            .hit_late  (hit_l),
            .sel       (sel_e)
         );

         assign sel_v[g] = sel_e;

         fwd_opmux #(.DATA_W(DATA_W), .MUX_STYLE(MUX_STYLE)) u_mux (
            .sel       (sel_v[g]),
            .rf_val    (rf_v[g]),
            .early_val (exm_res),
            .late_val  (mwb_res),
            .op_val    (op_v[g])
         );
      end
   endgenerate

   assign sel_a = sel_v[0];
   assign sel_b = sel_v[1];
   assign op_a  = op_v[0];
   assign op_b  = op_v[1];
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
   parameter int DATA_W = 32,
   parameter int REG_W  = 5
) (
   input logic [REG_W-1:0]  src_a_idx,
   input logic [REG_W-1:0]  src_b_idx,
   input logic [REG_W-1:0]  exm_dst,
   input logic              exm_wen,
   input logic [DATA_W-1:0] exm_res,
   input logic [REG_W-1:0]  mwb_dst,
   input logic              mwb_wen,
   input logic [DATA_W-1:0] mwb_res,
   input logic [DATA_W-1:0] rf_a_data,
   input logic [DATA_W-1:0] rf_b_data,
   input logic [1:0]        sel_a,
   input logic [1:0]        sel_b,
   input logic [DATA_W-1:0] op_a,
   input logic [DATA_W-1:0] op_b
);
   logic ea, eb, la, lb;
   assign ea = exm_wen && exm_dst != '0 && exm_dst == src_a_idx;
   assign eb = exm_wen && exm_dst != '0 && exm_dst == src_b_idx;
   assign la = mwb_wen && mwb_dst != '0 && mwb_dst == src_a_idx;
   assign lb = mwb_wen && mwb_dst != '0 && mwb_dst == src_b_idx;

   always_comb begin
      if (ea) AST_EARLY_WINS_A: assert (sel_a == 2'b10 && op_a == exm_res) else $error("early A"); // R3
      if (eb) AST_EARLY_WINS_B: assert (sel_b == 2'b10 && op_b == exm_res) else $error("early B"); // R1
      if (la && !ea) AST_LATE_A: assert (sel_a == 2'b01 && op_a == mwb_res) else $error("late A"); // R2
      if (lb && !eb) AST_LATE_B: assert (sel_b == 2'b01 && op_b == mwb_res) else $error("late B"); // R2
      if (!ea && !la) AST_RF_A: assert (sel_a == 2'b00 && op_a == rf_a_data) else $error("rf A"); // R6
      if (!eb && !lb) AST_RF_B: assert (sel_b == 2'b00 && op_b == rf_b_data) else $error("rf B"); // R6
      if (sel_a == 2'b10 || sel_b == 2'b10) AST_ZERO_DST_EARLY: assert (exm_dst != '0 && exm_wen) else $error("zero early"); // R4
      if (sel_a == 2'b01 || sel_b == 2'b01) AST_ZERO_DST_LATE: assert (mwb_dst != '0 && mwb_wen) else $error("zero late"); // R5
      AST_NO_RSVD_SEL: assert (sel_a != 2'b11 && sel_b != 2'b11) else $error("reserved select"); // R8
   end
endmodule

bind fwd_unit fwd_unit_chk #(.DATA_W(DATA_W), .REG_W(REG_W)) u_chk (
   .src_a_idx (src_a_idx),
   .src_b_idx (src_b_idx),
   .exm_dst   (exm_dst),
   .exm_wen   (exm_wen),
   .exm_res   (exm_res),
   .mwb_dst   (mwb_dst),
   .mwb_wen   (mwb_wen),
   .mwb_res   (mwb_res),
   .rf_a_data (rf_a_data),
   .rf_b_data (rf_b_data),
   .sel_a     (sel_a),
   .sel_b     (sel_b),
   .op_a      (op_a),
   .op_b      (op_b)
);

// File: tb/fwd_unit_tb.sv
module fwd_unit_tb;
   localparam int DATA_W = 32;
   localparam int REG_W  = 5;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #4 clk = ~clk;

   logic [REG_W-1:0]  src_a_idx, src_b_idx, exm_dst, mwb_dst;
   logic              exm_wen, mwb_wen;
   logic [DATA_W-1:0] exm_res, mwb_res, rf_a_data, rf_b_data;
   logic [1:0]        sel_a, sel_b;
   logic [DATA_W-1:0] op_a, op_b;

   fwd_unit #(.DATA_W(DATA_W), .REG_CNT(32)) u_dut (
      .src_a_idx (src_a_idx), .src_b_idx (src_b_idx),
      .exm_dst (exm_dst), .exm_wen (exm_wen), .exm_res (exm_res),
      .mwb_dst (mwb_dst), .mwb_wen (mwb_wen), .mwb_res (mwb_res),
      .rf_a_data (rf_a_data), .rf_b_data (rf_b_data),
      .sel_a (sel_a), .sel_b (sel_b), .op_a (op_a), .op_b (op_b)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   typedef struct packed {
      logic [4:0] sa;
      logic [4:0] sb;
      logic [4:0] ed;
      logic       ew;
      logic [4:0] md;
      logic       mw;
      logic [1:0] xa;
      logic [1:0] xb;
      logic [3:0] req;
   } vec_t;

   localparam int NVEC = 13;
   localparam vec_t VEC [NVEC] = '{
      '{5'd3,  5'd4,  5'd3,  1'b1, 5'd0,  1'b0, 2'b10, 2'b00, 4'd1}, // R1
      '{5'd3,  5'd4,  5'd4,  1'b1, 5'd0,  1'b0, 2'b00, 2'b10, 4'd1}, // R1
      '{5'd5,  5'd6,  5'd0,  1'b0, 5'd5,  1'b1, 2'b01, 2'b00, 4'd2}, // R2
      '{5'd5,  5'd6,  5'd9,  1'b1, 5'd6,  1'b1, 2'b00, 2'b01, 4'd2}, // R2
      '{5'd7,  5'd7,  5'd7,  1'b1, 5'd7,  1'b1, 2'b10, 2'b10, 4'd3}, // R3
      '{5'd7,  5'd8,  5'd7,  1'b1, 5'd8,  1'b1, 2'b10, 2'b01, 4'd7}, // R7
      '{5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 2'b00, 2'b00, 4'd4}, // R4
      '{5'd0,  5'd2,  5'd0,  1'b1, 5'd2,  1'b1, 2'b00, 2'b01, 4'd4}, // R4
      '{5'd3,  5'd4,  5'd3,  1'b0, 5'd3,  1'b0, 2'b00, 2'b00, 4'd5}, // R5
      '{5'd3,  5'd4,  5'd3,  1'b0, 5'd3,  1'b1, 2'b01, 2'b00, 4'd5}, // R5
      '{5'd10, 5'd11, 5'd12, 1'b1, 5'd13, 1'b1, 2'b00, 2'b00, 4'd6}, // R6
      '{5'd9,  5'd9,  5'd0,  1'b0, 5'd9,  1'b1, 2'b01, 2'b01, 4'd7}, // R7
      '{5'd31, 5'd30, 5'd31, 1'b1, 5'd30, 1'b1, 2'b10, 2'b01, 4'd1}  // R1
   };

   function automatic logic [DATA_W-1:0] pick(input logic [1:0] s,
                                              input logic [DATA_W-1:0] rf);
      if (s == 2'b10)      return exm_res;
      else if (s == 2'b01) return mwb_res;
      else                 return rf;
   endfunction

   function automatic logic [1:0] model_sel(input logic [4:0] s,
      input logic [4:0] ed, input logic ew, input logic [4:0] md, input logic mw);
      if (ew && ed != 0 && ed == s)      return 2'b10;
      else if (mw && md != 0 && md == s) return 2'b01;
      else                               return 2'b00;
   endfunction

   task automatic check(input string tag, input logic [1:0] xa, input logic [1:0] xb);
      logic [DATA_W-1:0] ea, eb;
      ea = pick(xa, rf_a_data);
      eb = pick(xb, rf_b_data);
      n_checks++;
      if (sel_a !== xa || sel_b !== xb || op_a !== ea || op_b !== eb) begin
         n_fail++;
         $display("FAIL %s: sel_a=%b sel_b=%b op_a=%h op_b=%h expected sel_a=%b sel_b=%b op_a=%h op_b=%h",
                  tag, sel_a, sel_b, op_a, op_b, xa, xb, ea, eb);
      end
   endtask

   task automatic drive(input logic [4:0] sa, input logic [4:0] sb, input logic [4:0] ed,
                        input logic ew, input logic [4:0] md, input logic mw);
      @(posedge clk);
      src_a_idx = sa; src_b_idx = sb;
      exm_dst = ed; exm_wen = ew; mwb_dst = md; mwb_wen = mw;
      @(negedge clk);
   endtask

   initial begin
      src_a_idx = '0; src_b_idx = '0; exm_dst = '0; mwb_dst = '0;
      exm_wen = 1'b0; mwb_wen = 1'b0;
      exm_res = 32'hE0E0_0001; mwb_res = 32'hB0B0_0002;
      rf_a_data = 32'hAAAA_0003; rf_b_data = 32'hBBBB_0004;
      repeat (3) @(negedge clk);
      check("R6 reset state", 2'b00, 2'b00);
      rst = 1'b0;

      for (int i = 0; i < NVEC; i++) begin
         drive(VEC[i].sa, VEC[i].sb, VEC[i].ed, VEC[i].ew, VEC[i].md, VEC[i].mw);
         check($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].xa, VEC[i].xb);
      end

      // R3: three dependent adds writing and reading register 1, operand B reads register 4
      rf_a_data = 32'h0000_0100;
      exm_res   = 32'h0000_0101;
      drive(5'd1, 5'd4, 5'd1, 1'b1, 5'd0, 1'b0);
      check("R3 second add in execute", 2'b10, 2'b00);
      mwb_res = 32'h0000_0101;
      exm_res = 32'h0000_0102;
      drive(5'd1, 5'd4, 5'd1, 1'b1, 5'd1, 1'b1);
      check("R3 third add in execute", 2'b10, 2'b00);
      n_checks++;
      if (op_a !== 32'h0000_0102) begin
         n_fail++;
         $display("FAIL R3 newest value: op_a=%h expected %h", op_a, 32'h0000_0102);
      end

      // R7 R8: sweep with few register numbers so collisions are common
      begin
         logic [31:0] lfsr = 32'hACE1_1234;
         for (int i = 0; i < 1500; i++) begin
            logic [4:0] sa, sb, ed, md;
            logic ew, mw;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            sa = {3'b0, lfsr[1:0]}; sb = {3'b0, lfsr[3:2]};
            ed = {3'b0, lfsr[5:4]}; md = {3'b0, lfsr[7:6]};
            ew = lfsr[8]; mw = lfsr[9];
            exm_res = {16'hE000, lfsr[31:16]};
            mwb_res = {16'h5000, lfsr[31:16]};
            drive(sa, sb, ed, ew, md, mw);
            check("R7 sweep", model_sel(sa, ed, ew, md, mw), model_sel(sb, ed, ew, md, mw));
            n_checks++;
            if (sel_a == 2'b11 || sel_b == 2'b11) begin
               n_fail++;
               $display("FAIL R8 reserved select: sel_a=%b sel_b=%b expected neither 11", sel_a, sel_b);
            end
         end
      end

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule